// File: doc/BRIEF.md
# Floating-Point Sign Injection Unit

This block computes the three sign-injection operations of a scalar floating-point unit: copy a sign, copy an inverted sign, and XOR two signs. Operands A and B arrive in 64-bit register containers. A 2-bit format select picks half (16-bit), single (32-bit) or double (64-bit) precision. The result keeps every non-sign bit of operand A exactly as it arrived. Only the sign bit, which is the top bit of the selected format, is replaced. No exponent or mantissa processing takes place, NaN payloads survive unchanged, and the unit has no exception flags.

The sign is chosen by a flat tree of 2:1 multiplexers and XOR gates. One lane is built per format and a multiplexer selects among them. A single output register follows, with valid/ready handshakes on both sides, so a new operation can be accepted every cycle. Move, negate and absolute value come from driving the same register into A and B with op 00, 01 or 10.

Top module: `fp_sign_inject`

## Requirements
- R1: Within the selected format, every bit of the result below the sign bit equals the same bit of operand A, NaN payloads included.
- R2: Op 2'b00 sets the result sign to the sign of B.
- R3: Op 2'b01 sets the result sign to the inverse of the sign of B.
- R4: Op 2'b10 sets the result sign to the sign of A XOR the sign of B.
- R5: Op 2'b11 gives exactly the result of op 2'b10.
- R6: The format select encodes 2'b00 as half (sign at bit 15), 2'b01 as single (sign at bit 31), and 2'b10 or 2'b11 as double (sign at bit 63).
- R7: For half and single, all result bits above the format's sign bit are ones, and the input bits above the format width have no effect on the result.
- R8: An operation accepted at a clock edge (in_valid and in_ready both high) appears on out_data with out_valid high after that edge.
- R9: in_ready is high whenever the output register is empty or out_ready is high, so a steady stream sustains one result per cycle.
- R10: While out_valid is high and out_ready is low, out_valid and out_data stay unchanged and no new operation is taken.
- R11: After synchronous reset, out_valid is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operation offered |
| in_ready | output | 1 | Operation can be taken this cycle |
| in_op | input | 2 | Sign operation: 00 copy, 01 invert, 10/11 XOR |
| in_fmt | input | 2 | Format: 00 half, 01 single, 10/11 double |
| in_a | input | 64 | Operand A, the source of the magnitude bits |
| in_b | input | 64 | Operand B, the source of the sign |
| out_valid | output | 1 | Result register holds a result |
| out_ready | input | 1 | Consumer takes the result this cycle |
| out_data | output | 64 | Result |

## Verification
Random operands are drawn over all op and format codes, including the reserved ones. This separates the four sign rules from one another and shows whether the sign is taken from the correct bit position. Directed cases use a quiet NaN with a payload, to show that the payload is preserved, and half and single operands with junk in their upper bits, to show those bits are ignored and replaced with ones. A back-to-back stream and a stall with out_ready low distinguish correct throughput from holding the output, and a lost or repeated result from a correct one.

// File: rtl/fsinj_pkg.sv
package fsinj_pkg;
  typedef enum logic [1:0] {
    FMT_HALF   = 2'b00,
    FMT_SINGLE = 2'b01,
    FMT_DOUBLE = 2'b10,
    FMT_ALT    = 2'b11
  } fsinj_fmt_e;

  typedef enum logic [1:0] {
    OP_COPY = 2'b00,
    OP_INV  = 2'b01,
    OP_XOR  = 2'b10,
    OP_ALT  = 2'b11
  } fsinj_op_e;

  localparam int NUM_LANES = 3;
endpackage

// File: rtl/fsinj_sign_sel.sv
module fsinj_sign_sel (
  input  logic [1:0] op,
  input  logic       sign_a,
  input  logic       sign_b,
  output logic       sign_r
);
  logic copy_or_inv;
  logic xor_sign;

  // op[0] flips B's sign for the invert case; op[1] picks the XOR path (11 aliases 10)
  assign copy_or_inv = sign_b ^ op[0];
  assign xor_sign    = sign_a ^ sign_b;
  assign sign_r      = op[1] ? xor_sign : copy_or_inv;
endmodule

// File: rtl/fsinj_lanes.sv
module fsinj_lanes #(
  parameter int DATA_W = 64
) (
  input  logic [1:0]        op,
  input  logic [1:0]        fmt,
  input  logic [DATA_W-1:0] a,
  input  logic [DATA_W-1:0] b,
  output logic [DATA_W-1:0] res
);
  import fsinj_pkg::*;

  logic [DATA_W-1:0] lane_res [NUM_LANES];

  for (genvar g = 0; g < NUM_LANES; g++) begin : g_lane
    localparam int W = DATA_W >> (NUM_LANES - 1 - g);
    logic sgn;

    fsinj_sign_sel u_sel (
      .op     (op),
      .sign_a (a[W-1]),
      .sign_b (b[W-1]),
      .sign_r (sgn)
    );

    if (W == DATA_W) begin : g_full
      assign lane_res[g] = {sgn, a[W-2:0]};
    end else begin : g_boxed
      assign lane_res[g] = {{(DATA_W-W){1'b1}}, sgn, a[W-2:0]};
    end
  end

  // format select as a 2:1 mux tree; 11 falls into the double lane
  assign res = fmt[1] ? lane_res[2] : (fmt[0] ? lane_res[1] : lane_res[0]);
endmodule

// File: rtl/fsinj_stage.sv
module fsinj_stage #(
  parameter int DATA_W = 64
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [DATA_W-1:0] in_data,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [DATA_W-1:0] out_data
);
  logic              vld_q;
  logic [DATA_W-1:0] data_q;
  logic              take;

  assign in_ready  = !vld_q || out_ready;
  assign take      = in_valid && in_ready;
  assign out_valid = vld_q;
  assign out_data  = data_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      vld_q <= 1'b0;
    end else if (take) begin
      vld_q <= 1'b1;
    end else if (out_ready) begin
      vld_q <= 1'b0;
    end
  end

  // datapath register needs no reset
  always_ff @(posedge clk) begin
    if (take) begin
      data_q <= in_data;
    end
  end

  // R8: an accepted operation shows up after the edge
  a_r8_accept_lands: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_ready) |=> out_valid);

  // R10: stalled output holds
  a_r10_hold_stable: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

  // R9: empty stage always accepts
  a_r9_empty_ready: assert property (@(posedge clk) disable iff (rst)
    !out_valid |-> in_ready);
endmodule

// File: rtl/fp_sign_inject.sv
module fp_sign_inject #(
  parameter int DATA_W = 64
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [1:0]        in_op,
  input  logic [1:0]        in_fmt,
  input  logic [DATA_W-1:0] in_a,
  input  logic [DATA_W-1:0] in_b,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [DATA_W-1:0] out_data
);
  localparam int HALF_W = DATA_W / 4;

  logic [DATA_W-1:0] comb_res;

  fsinj_lanes #(.DATA_W(DATA_W)) u_lanes (
    .op  (in_op),
    .fmt (in_fmt),
    .a   (in_a),
    .b   (in_b),
    .res (comb_res)
  );

  fsinj_stage #(.DATA_W(DATA_W)) u_stage (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .in_data   (comb_res),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_data  (out_data)
  );

  // R1: double-format magnitude bits pass through the register unchanged
  a_r1_double_magnitude: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_ready && in_fmt[1]) |=> (out_data[DATA_W-2:0] == $past(in_a[DATA_W-2:0])));

  // R7: half-format results are boxed with ones
  a_r7_half_boxed: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_ready && in_fmt == 2'b00) |=> (&out_data[DATA_W-1:HALF_W]));

  // R2: copy op on double takes B's sign
  a_r2_copy_sign: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_ready && in_fmt == 2'b10 && in_op == 2'b00)
      |=> (out_data[DATA_W-1] == $past(in_b[DATA_W-1])));
endmodule

// File: tb/fp_sign_inject_tb.sv
module fp_sign_inject_tb;
  localparam int CLK_PERIOD = 10;
  localparam int DW = 64;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          in_valid = 1'b0;
  logic          in_ready;
  logic [1:0]    in_op = '0;
  logic [1:0]    in_fmt = '0;
  logic [DW-1:0] in_a = '0;
  logic [DW-1:0] in_b = '0;
  logic          out_valid;
  logic          out_ready = 1'b1;
  logic [DW-1:0] out_data;

  int n_chk = 0;
  int n_bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  fp_sign_inject #(.DATA_W(DW)) u_dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .in_op(in_op), .in_fmt(in_fmt), .in_a(in_a), .in_b(in_b),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data)
  );

  function automatic logic [DW-1:0] model(input logic [1:0] op, input logic [1:0] fmt,
                                          input logic [DW-1:0] a, input logic [DW-1:0] b);
    int w;
    logic sa, sb, s;
    logic [DW-1:0] r;
    w  = (fmt == 2'b00) ? 16 : (fmt == 2'b01) ? 32 : 64;
    sa = a[w-1];
    sb = b[w-1];
    case (op)
      2'b00:   s = sb;
      2'b01:   s = ~sb;
      default: s = sa ^ sb;
    endcase
    r = '1;
    for (int k = 0; k < w - 1; k++) r[k] = a[k];
    r[w-1] = s;
    return r;
  endfunction

  task automatic check(input bit ok, input string tag, input logic [DW-1:0] act,
                       input logic [DW-1:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // single operation with open output: drive at negedge, look one negedge later
  task automatic one_op(input logic [1:0] op, input logic [1:0] fmt,
                        input logic [DW-1:0] a, input logic [DW-1:0] b, input string tag);
    logic [DW-1:0] e;
    e = model(op, fmt, a, b);
    @(negedge clk);
    in_valid = 1'b1; in_op = op; in_fmt = fmt; in_a = a; in_b = b;
    @(negedge clk);
    in_valid = 1'b0;
    check(out_valid && out_data == e, tag, out_data, e);
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog actual=%h expected=%h", 64'd0, 64'd1);
    finish_run();
  end

  initial begin
    logic [DW-1:0] ea, eb, prev;
    void'($urandom(32'd1234));
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R11: reset state
    check(out_valid == 1'b0, "R11 reset valid", {63'd0, out_valid}, 64'd0);
    rst = 1'b0;
    @(negedge clk);
    check(in_ready == 1'b1, "R9 idle ready", {63'd0, in_ready}, 64'd1);

    // directed corners
    one_op(2'b00, 2'b10, 64'h0123_4567_89AB_CDEF, 64'h8000_0000_0000_0000, "R2 copy double");
    one_op(2'b01, 2'b10, 64'h8123_4567_89AB_CDEF, 64'h8000_0000_0000_0000, "R3 invert double");
    one_op(2'b10, 2'b10, 64'h8123_4567_89AB_CDEF, 64'h8000_0000_0000_0000, "R4 xor double");
    one_op(2'b11, 2'b10, 64'h8123_4567_89AB_CDEF, 64'h0000_0000_0000_0000, "R5 alt op xor");
    one_op(2'b00, 2'b01, 64'hFFFF_FFFF_7FC1_2345, 64'h0000_0000_8000_0000, "R1 NaN payload single");
    one_op(2'b00, 2'b00, 64'h1234_5678_9ABC_7E01, 64'hDEAD_BEEF_0000_8000, "R7 half junk upper");
    one_op(2'b01, 2'b01, 64'h0000_0000_3F80_0000, 64'hFFFF_FFFF_7FFF_FFFF, "R6 single sign bit");
    one_op(2'b00, 2'b11, 64'h7FF8_0000_0000_0001, 64'hFFFF_FFFF_FFFF_FFFF, "R6 fmt 11 as double");
    one_op(2'b01, 2'b00, 64'h0000_0000_0000_FFFF, 64'h0000_0000_0000_7FFF, "R3 half invert");

    // R8 R9: back-to-back stream, one result per cycle
    for (int i = 0; i < 200; i++) begin
      @(negedge clk);
      if (i > 0) check(out_valid && out_data == prev, "R8 stream result", out_data, prev);
      check(in_ready == 1'b1, "R9 stream ready", {63'd0, in_ready}, 64'd1);
      in_valid = 1'b1;
      in_op = 2'($urandom); in_fmt = 2'($urandom);
      in_a = {$urandom, $urandom}; in_b = {$urandom, $urandom};
      if (i % 7 == 0) in_a[62:52] = '1;
      prev = model(in_op, in_fmt, in_a, in_b);
    end
    @(negedge clk);
    in_valid = 1'b0;
    check(out_valid && out_data == prev, "R8 stream last", out_data, prev);
    @(negedge clk);
    check(out_valid == 1'b0, "R8 drains", {63'd0, out_valid}, 64'd0);

    // R10: stall with out_ready low
    ea = model(2'b10, 2'b01, 64'hAAAA_AAAA_C000_0001, 64'h0000_0000_8000_0000);
    eb = model(2'b00, 2'b10, 64'h4010_0000_0000_0000, 64'h8000_0000_0000_0000);
    out_ready = 1'b0;
    in_valid = 1'b1; in_op = 2'b10; in_fmt = 2'b01;
    in_a = 64'hAAAA_AAAA_C000_0001; in_b = 64'h0000_0000_8000_0000;
    @(negedge clk);
    check(out_valid && out_data == ea, "R10 first held", out_data, ea);
    check(in_ready == 1'b0, "R9 stalled not ready", {63'd0, in_ready}, 64'd0);
    in_op = 2'b00; in_fmt = 2'b10;
    in_a = 64'h4010_0000_0000_0000; in_b = 64'h8000_0000_0000_0000;
    @(negedge clk);
    check(out_valid && out_data == ea, "R10 stall keeps data", out_data, ea);
    out_ready = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    check(out_valid && out_data == eb, "R10 next after release", out_data, eb);
    @(negedge clk);
    check(out_valid == 1'b0, "R10 no duplicate", {63'd0, out_valid}, 64'd0);

    // R11: reset in the middle clears valid
    in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    rst = 1'b1;
    @(negedge clk);
    check(out_valid == 1'b0, "R11 reset clears", {63'd0, out_valid}, 64'd0);
    rst = 1'b0;
    @(negedge clk);
    finish_run();
  end
endmodule